// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links two 8-bit buses, called A and B. Each bus appears as three signals: an input, an output and an output enable. It has no true tristate pins. An active-low enable and a direction input decide which bus the block drives, if it drives either one. The two buses are never driven in the same cycle.

Each side has its own capture register with its own capture strobe. The A-side register samples the A bus, and the B-side register samples the B bus. Each register loads on the rising edge of its strobe, as seen in the system clock domain. The settings of enable and direction never block a load, so data can be stored while the block is isolated.

The driven bus takes its data from a selector. The selector passes either the live value of the opposite bus or the register that stored that bus earlier. When the block samples a bus it is itself driving, the register stores the value the block puts out, not the external input.

Top module: `xcvr_reg_bidir`

## Requirements
- R1: A synchronous active-high reset clears both capture registers to zero. After reset, a stored-source transfer onto either bus yields 0x00.
- R2: While `oe_n` is 1, both `a_oe` and `b_oe` are 0, and `a_out` and `b_out` read 0x00.
- R3: With `oe_n`=0 and `dir`=0, `a_oe` is 1 and `b_oe` is 0.
- R4: With `oe_n`=0 and `dir`=1, `b_oe` is 1 and `a_oe` is 0.
- R5: The A-side register loads in a clock cycle where `cap_ab` is 1 and was 0 at the previous clock edge. Holding `cap_ab` at 1 does not reload the register.
- R6: The B-side register loads in the same way on a rising edge of `cap_ba`.
- R7: Loading is never gated by `oe_n` or `dir`. Data captured while isolated is kept and can be replayed later.
- R8: While A is driven, `a_out` equals the live `b_in` when `sel_ba`=0, and equals the B-side register when `sel_ba`=1. The path is combinational and takes effect in the same cycle.
- R9: While B is driven, `b_out` equals the live `a_in` when `sel_ab`=0, and equals the A-side register when `sel_ab`=1.
- R10: `a_oe` and `b_oe` are never 1 at the same time, for any input combination.
- R11: While the block drives a bus, that bus's register captures the driven value (`a_out` or `b_out`) and ignores the external input.
- R12: Changing `sel_ab` or `sel_ba` never changes either register's contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Enable, active low; when 1 both buses are isolated |
| dir | input | 1 | 0 drives bus A, 1 drives bus B |
| cap_ab | input | 1 | Capture strobe for the A-side register (rising edge) |
| cap_ba | input | 1 | Capture strobe for the B-side register (rising edge) |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value driven onto bus A, 0 when not driven |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value driven onto bus B, 0 when not driven |
| b_oe | output | 1 | Bus B output enable |

## Verification
The assertions assume that the strobes, selects, enable and direction are synchronous to `clk` and stable around its edge. They also assume that reset lasts at least one edge. The stored-value hold checks depend on this: they treat the absence of a strobe rise at an edge as proof that the register did not load.

The stimulus changes every input shortly after a rising edge and keeps both strobes low during reset. Each strobe is raised for exactly the cycles under test. That keeps every register load at a known edge for the bench's own model.

// File: rtl/tcvr_pkg.sv
package tcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;
endpackage

// File: rtl/tcvr_dir_dec.sv
module tcvr_dir_dec
  import tcvr_pkg::*;
(
  input  logic   oe_n,
  input  logic   dir,
  output drive_e mode,
  output logic   a_oe,
  output logic   b_oe
);
  always_comb begin
    if (oe_n)     mode = DRV_NONE;
    else if (dir) mode = DRV_B;
    else          mode = DRV_A;
  end

  assign a_oe = (mode == DRV_A);
  assign b_oe = (mode == DRV_B);
endmodule

// File: rtl/tcvr_cap_reg.sv
module tcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic load;

  assign load = strobe && !strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/tcvr_out_mux.sv
module tcvr_out_mux #(
  parameter int W = 8
) (
  input  logic         en,
  input  logic         sel_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] q
);
  always_comb begin
    if (!en)             q = '0;
    else if (sel_stored) q = stored;
    else                 q = live;
  end
endmodule

// File: rtl/xcvr_reg_bidir.sv
module xcvr_reg_bidir #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  import tcvr_pkg::*;

  drive_e       mode;
  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  logic [W-1:0] seen_a;
  logic [W-1:0] seen_b;

  tcvr_dir_dec u_dec (
    .oe_n (oe_n),
    .dir  (dir),
    .mode (mode),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );

  // A register samples the bus as it really is: the block's own drive when A is driven.
  assign seen_a = (mode == DRV_A) ? a_out : a_in;
  assign seen_b = (mode == DRV_B) ? b_out : b_in;

  tcvr_cap_reg #(.W(W)) u_reg_a (
    .clk    (clk),
    .rst    (rst),
    .strobe (cap_ab),
    .d      (seen_a),
    .q      (reg_a)
  );

  tcvr_cap_reg #(.W(W)) u_reg_b (
    .clk    (clk),
    .rst    (rst),
    .strobe (cap_ba),
    .d      (seen_b),
    .q      (reg_b)
  );

  tcvr_out_mux #(.W(W)) u_mux_a (
    .en         (a_oe),
    .sel_stored (sel_ba),
    .live       (b_in),
    .stored     (reg_b),
    .q          (a_out)
  );

  tcvr_out_mux #(.W(W)) u_mux_b (
    .en         (b_oe),
    .sel_stored (sel_ab),
    .live       (a_in),
    .stored     (reg_a),
    .q          (b_out)
  );
endmodule

// File: rtl/tcvr_chk.sv
module tcvr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         oe_n,
  input logic         dir,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  AST_OE_EXCL: assert property (@(posedge clk) disable iff (rst) !(a_oe && b_oe)); // R10
  AST_ISOLATE: assert property (@(posedge clk) disable iff (rst) oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0)); // R2
  AST_DRIVE_A: assert property (@(posedge clk) disable iff (rst) (!oe_n && !dir) |-> (a_oe && !b_oe)); // R3
  AST_DRIVE_B: assert property (@(posedge clk) disable iff (rst) (!oe_n && dir) |-> (b_oe && !a_oe)); // R4
  AST_LIVE_A: assert property (@(posedge clk) disable iff (rst) (a_oe && !sel_ba) |-> a_out == b_in); // R8
  AST_LIVE_B: assert property (@(posedge clk) disable iff (rst) (b_oe && !sel_ab) |-> b_out == a_in); // R9
  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
    (!rst && b_oe && sel_ab && !cap_ab) |=> ((b_oe && sel_ab) |-> $stable(b_out))); // R12
  AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
    (!rst && a_oe && sel_ba && !cap_ba) |=> ((a_oe && sel_ba) |-> $stable(a_out))); // R12
endmodule

bind xcvr_reg_bidir tcvr_chk #(.W(W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .oe_n   (oe_n),
  .dir    (dir),
  .cap_ab (cap_ab),
  .cap_ba (cap_ba),
  .sel_ab (sel_ab),
  .sel_ba (sel_ba),
  .a_in   (a_in),
  .a_out  (a_out),
  .a_oe   (a_oe),
  .b_in   (b_in),
  .b_out  (b_out),
  .b_oe   (b_oe)
);

// File: tb/xcvr_reg_bidir_tb.sv
module xcvr_reg_bidir_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] m_a, m_b;

  always #4 clk = ~clk;

  xcvr_reg_bidir #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // read stored A via bus B and stored B via bus A (purely combinational reads)
  task automatic read_stored(output logic [W-1:0] ra, output logic [W-1:0] rb);
    oe_n = 0; dir = 1; sel_ab = 1; #1; ra = b_out;
    dir = 0; sel_ba = 1; #1; rb = a_out;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [W-1:0] ra, rb;
    rst = 1; oe_n = 1; dir = 0; cap_ab = 0; cap_ba = 0; sel_ab = 0; sel_ba = 0;
    a_in = 8'hFF; b_in = 8'hEE;
    step(); step();
    // R2: isolated during reset hold
    chk("R2 a_oe", {7'b0, a_oe}, 8'h00);
    chk("R2 b_oe", {7'b0, b_oe}, 8'h00);
    rst = 0;
    step();
    read_stored(ra, rb);
    chk("R1 reg A", ra, 8'h00);
    chk("R1 reg B", rb, 8'h00);
    m_a = 0; m_b = 0;

    // R7/R5/R6: capture while isolated
    oe_n = 1; a_in = 8'h5A; b_in = 8'hC3; cap_ab = 1; cap_ba = 1;
    step();
    m_a = 8'h5A; m_b = 8'hC3;
    // R5: hold strobe high, change data, no reload
    a_in = 8'h01; b_in = 8'h02;
    step();
    cap_ab = 0; cap_ba = 0;
    step();
    read_stored(ra, rb);
    chk("R7 R5 reg A", ra, m_a);
    chk("R7 R6 reg B", rb, m_b);

    // Sweep all control combinations over several data patterns (R2 R3 R4 R8 R9 R10)
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 16; c++) begin
        logic e_aoe, e_boe;
        logic [W-1:0] e_a, e_b;
        a_in = 8'(p * 37 + 11); b_in = 8'(p * 91 + 5);
        {oe_n, dir, sel_ab, sel_ba} = 4'(c);
        #1;
        e_aoe = !oe_n && !dir;
        e_boe = !oe_n && dir;
        e_a = e_aoe ? (sel_ba ? m_b : b_in) : '0;
        e_b = e_boe ? (sel_ab ? m_a : a_in) : '0;
        chk("R3 a_oe", {7'b0, a_oe}, {7'b0, e_aoe});
        chk("R4 b_oe", {7'b0, b_oe}, {7'b0, e_boe});
        chk("R10 excl", {7'b0, a_oe & b_oe}, 8'h00);
        chk("R8 a_out", a_out, e_a);
        chk("R9 b_out", b_out, e_b);
        if (oe_n) chk("R2 iso", a_out | b_out, 8'h00);
      end
    end

    // R12: toggle selects over several edges, registers unchanged
    for (int k = 0; k < 6; k++) begin
      sel_ab = k[0]; sel_ba = k[1]; oe_n = k[2]; dir = k[0];
      step();
    end
    read_stored(ra, rb);
    chk("R12 reg A", ra, m_a);
    chk("R12 reg B", rb, m_b);

    // R11: A driven from live B; capture A sees driven value
    oe_n = 0; dir = 0; sel_ba = 0; a_in = 8'h11; b_in = 8'h77;
    step();
    cap_ab = 1; step(); cap_ab = 0; step();
    m_a = 8'h77;
    read_stored(ra, rb);
    chk("R11 loop A", ra, 8'h77);
    // R11: B driven from stored A; capture B sees driven value
    oe_n = 0; dir = 1; sel_ab = 1; b_in = 8'h99;
    step();
    cap_ba = 1; step(); cap_ba = 0; step();
    m_b = m_a;
    read_stored(ra, rb);
    chk("R11 loop B", rb, 8'h77);

    // R6: fresh capture of B while B is an input
    oe_n = 0; dir = 0; sel_ba = 1; b_in = 8'h3C;
    step();
    cap_ba = 1; step(); cap_ba = 0; step();
    #1;
    chk("R6 reg B replay", a_out, 8'h3C);

    // R1: reset clears after use
    rst = 1; step(); rst = 0; step();
    read_stored(ra, rb);
    chk("R1 reset reg A", ra, 8'h00);
    chk("R1 reset reg B", rb, 8'h00);

    finish_run();
  end
endmodule